// File: doc/BRIEF.md
# Upstream D-Channel Priority Arbiter

This block decides who may use a shared upstream D-channel. Two kinds of contender want it: local HDLC controllers that sit on a time-multiplexed serial bus, and the terminals attached on the line side. Once per frame, a strobe marks the D-bit slot. On that strobe the arbiter samples the upstream D-bit and counts how many ones have arrived in a row. A local controller asks for the channel by pulling its active-low request bit to 0.

When the run of ones reaches the priority threshold and a request is pending, the arbiter grants the channel in that same slot. It tells the HDLC side through a stop/go bit. While the grant lasts, the echo bit returned to the line is the inverse of the received D-bit. The line terminals therefore see a collision and back off. Without a grant, the echo simply mirrors the D-bit, so the line terminals contend among themselves in the normal way.

Arbitration runs only when the 3-bit mode field selects the intelligent network-termination mode.

Top module: `dch_arbiter`

## Requirements
- R1: Arbitration is active only while `mode_cfg` equals 3'b011 (parameter `NT_MODE`). With any other value, no grant is held, `stop_go` is 0 and `echo` mirrors the D-bit of each strobed slot. Leaving the mode drops a held grant on the next clock.
- R2: On each strobed slot, a D-bit of 1 raises the ones count by one, and the count saturates at 10. A D-bit of 0 clears the count to zero.
- R3: The threshold is 8 ones when `prio_sel` is 0 and 10 ones when `prio_sel` is 1.
- R4: A grant is taken on the strobe whose updated ones count is at or above the threshold while `req_n` is 0. The grant is visible after that clock edge.
- R5: While a grant is held after a strobe, `echo` takes the inverse of that slot's D-bit.
- R6: Without a grant after a strobe, `echo` takes that slot's D-bit unchanged.
- R7: `stop_go` is 1 (go) while a grant is held, or while the mode is active and the ones count is at or above the threshold. Otherwise it is 0 (stop).
- R8: A held grant is released on a strobe with `req_n` at 1. The ones count then restarts from zero, so a full threshold of new ones is needed before `stop_go` returns to 1.
- R9: With the mode held constant, nothing changes between strobes: `stop_go` and `echo` keep their values whatever `d_bit` and `req_n` do.
- R10: After a synchronous reset, `stop_go` is 0, `echo` is 1 and the ones count is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_stb | input | 1 | One-cycle pulse marking the D-bit slot of a frame |
| d_bit | input | 1 | Upstream D-channel bit for the current slot |
| req_n | input | 1 | Local controller request, 0 = requesting |
| prio_sel | input | 1 | Threshold select: 0 = 8 ones, 1 = 10 ones |
| mode_cfg | input | 3 | Operating mode; 3'b011 enables arbitration |
| stop_go | output | 1 | Access indication to local controllers, 1 = go |
| echo | output | 1 | Echo bit sent to line-side terminals |

## Verification
The bench builds the block with its default thresholds of 8 and 10 and the default mode code. Both priority levels are therefore reachable within a dozen strobed slots, and so are the saturation corner, where a count of 10 taken under threshold 8 still satisfies threshold 10. The directed scenarios cover several cases: a zero breaking a run just short of the threshold, a request that waits through the count and wins on the exact slot the threshold is met, and a release followed by a fresh count. They also check that inputs are ignored between strobes and that leaving the mode drops a held grant.

// File: rtl/dch_arb_pkg.sv
package dch_arb_pkg;

    // who owns the upstream D-channel right now
    typedef enum logic {
        OWN_FREE  = 1'b0,
        OWN_LOCAL = 1'b1
    } own_e;

    // one strobed D-bit slot as seen by the arbiter
    typedef struct packed {
        logic stb;
        logic dbit;
        logic req_n;
    } slot_t;

    function automatic logic mode_match(input logic [2:0] mode, input logic [2:0] code);
        return mode == code;
    endfunction

endpackage

// File: rtl/dch_ones_count.sv
module dch_ones_count #(
    parameter int LO = 8,
    parameter int HI = 10,
    parameter int W  = $clog2(HI + 1)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         stb,
    input  logic         dbit,
    input  logic         prio,
    output logic [W-1:0] cnt_q,
    output logic         hit_nxt,
    output logic         hit_q
);
    localparam logic [W-1:0] THR_LO = W'(LO);
    localparam logic [W-1:0] THR_HI = W'(HI);

    logic [W-1:0] thr;
    logic [W-1:0] cnt_inc;

    assign thr     = prio ? THR_HI : THR_LO;
    assign cnt_inc = dbit ? ((cnt_q >= THR_HI) ? THR_HI : cnt_q + 1'b1) : '0;
    assign hit_nxt = cnt_inc >= thr;
    assign hit_q   = cnt_q >= thr;

    always_ff @(posedge clk) begin
        if (rst || clr) cnt_q <= '0;
        else if (stb)   cnt_q <= cnt_inc;
    end

    // R2: count never passes the saturation value
    p_cnt_cap_r2: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= THR_HI);

    // R2: a zero in a counted slot leaves the count at zero
    p_zero_clears_r2: assert property (@(posedge clk) disable iff (rst)
        (stb && !clr && !dbit) |=> (cnt_q == '0));

endmodule

// File: rtl/dch_grant_ctrl.sv
module dch_grant_ctrl
    import dch_arb_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  active,
    input  slot_t slot,
    input  logic  hit_nxt,
    output own_e  own_q,
    output logic  take,
    output logic  own_nxt
);
    logic drop;

    assign take = active && slot.stb && (own_q == OWN_FREE) && !slot.req_n && hit_nxt;
    assign drop = slot.stb && (own_q == OWN_LOCAL) && slot.req_n;

    always_comb begin
        if (!active)   own_nxt = 1'b0;
        else if (take) own_nxt = 1'b1;
        else if (drop) own_nxt = 1'b0;
        else           own_nxt = (own_q == OWN_LOCAL);
    end

    always_ff @(posedge clk) begin
        if (rst) own_q <= OWN_FREE;
        else     own_q <= own_nxt ? OWN_LOCAL : OWN_FREE;
    end

    // R1: leaving the mode drops any grant
    p_off_free_r1: assert property (@(posedge clk) disable iff (rst)
        !active |=> (own_q == OWN_FREE));

    // R8: request withdrawn on a strobe releases the channel
    p_release_r8: assert property (@(posedge clk) disable iff (rst)
        (slot.stb && slot.req_n && own_q == OWN_LOCAL) |=> (own_q == OWN_FREE));

    // R9: ownership is only decided on strobes
    p_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        (!slot.stb && active) |=> ($stable(own_q) || !active));

endmodule

// File: rtl/dch_echo_gen.sv
module dch_echo_gen (
    input  logic clk,
    input  logic rst,
    input  logic stb,
    input  logic dbit,
    input  logic own_nxt,
    output logic echo_q
);
    always_ff @(posedge clk) begin
        if (rst)      echo_q <= 1'b1;
        else if (stb) echo_q <= dbit ^ own_nxt;
    end
endmodule

// File: rtl/dch_arbiter.sv
module dch_arbiter
    import dch_arb_pkg::*;
#(
    parameter int          CNT_LO  = 8,
    parameter int          CNT_HI  = 10,
    parameter logic [2:0]  NT_MODE = 3'b011
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       frame_stb,
    input  logic       d_bit,
    input  logic       req_n,
    input  logic       prio_sel,
    input  logic [2:0] mode_cfg,
    output logic       stop_go,
    output logic       echo
);
    localparam int CW = $clog2(CNT_HI + 1);

    slot_t         slot;
    logic          active;
    logic [CW-1:0] cnt_q;
    logic          hit_nxt;
    logic          hit_q;
    own_e          own_q;
    logic          take;
    logic          own_nxt;
    logic          cnt_clr;

    assign slot    = '{stb: frame_stb, dbit: d_bit, req_n: req_n};
    assign active  = mode_match(mode_cfg, NT_MODE);
    assign cnt_clr = !active || (own_q == OWN_LOCAL) || take;

    dch_ones_count #(.LO(CNT_LO), .HI(CNT_HI), .W(CW)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .clr     (cnt_clr),
        .stb     (slot.stb),
        .dbit    (slot.dbit),
        .prio    (prio_sel),
        .cnt_q   (cnt_q),
        .hit_nxt (hit_nxt),
        .hit_q   (hit_q)
    );

    dch_grant_ctrl u_grant (
        .clk     (clk),
        .rst     (rst),
        .active  (active),
        .slot    (slot),
        .hit_nxt (hit_nxt),
        .own_q   (own_q),
        .take    (take),
        .own_nxt (own_nxt)
    );

    dch_echo_gen u_echo (
        .clk     (clk),
        .rst     (rst),
        .stb     (slot.stb),
        .dbit    (slot.dbit),
        .own_nxt (own_nxt),
        .echo_q  (echo)
    );

    assign stop_go = (own_q == OWN_LOCAL) || (active && hit_q);

    // R5: held grant inverts the echo of the slot just strobed
    p_echo_inv_r5: assert property (@(posedge clk) disable iff (rst)
        frame_stb |=> ((own_q != OWN_LOCAL) || (echo == !$past(d_bit))));

    // R6: without a grant the echo follows the slot's D-bit
    p_echo_mirror_r6: assert property (@(posedge clk) disable iff (rst)
        frame_stb |=> ((own_q == OWN_LOCAL) || (echo == $past(d_bit))));

    // R4: a grant never appears without a request in the strobed slot
    p_grant_needs_req_r4: assert property (@(posedge clk) disable iff (rst)
        (own_q == OWN_FREE && !(frame_stb && !req_n)) |=> (own_q == OWN_FREE));

    // R2: the ones count stays zero while a grant is held
    p_cnt_idle_r2: assert property (@(posedge clk) disable iff (rst)
        (own_q == OWN_LOCAL) |-> (cnt_q == '0));

endmodule

// File: tb/tb_dch_arbiter.sv
module tb_dch_arbiter;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic       frame_stb;
    logic       d_bit;
    logic       req_n;
    logic       prio_sel;
    logic [2:0] mode_cfg;
    logic       stop_go;
    logic       echo;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #(CLK_P/2) clk = ~clk;

    dch_arbiter dut (
        .clk       (clk),
        .rst       (rst),
        .frame_stb (frame_stb),
        .d_bit     (d_bit),
        .req_n     (req_n),
        .prio_sel  (prio_sel),
        .mode_cfg  (mode_cfg),
        .stop_go   (stop_go),
        .echo      (echo)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic prio, input logic [2:0] mode);
        @(negedge clk);
        rst = 1'b1; frame_stb = 1'b0; d_bit = 1'b1; req_n = 1'b1;
        prio_sel = prio; mode_cfg = mode;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    // one strobed slot; returns at the next falling edge with outputs settled
    task automatic frame(input logic d, input logic rq);
        @(negedge clk);
        d_bit = d; req_n = rq; frame_stb = 1'b1;
        @(negedge clk);
        frame_stb = 1'b0;
    endtask

    task automatic t_reset;
        do_reset(1'b0, 3'b011);
        check("R10 stop_go after reset", stop_go, 1'b0);
        check("R10 echo after reset", echo, 1'b1);
        for (int i = 0; i < 7; i++) frame(1'b1, 1'b1);
        check("R10 count starts at zero (7 ones)", stop_go, 1'b0);
    endtask

    task automatic t_count8;
        do_reset(1'b0, 3'b011);
        for (int i = 0; i < 7; i++) begin
            frame(1'b1, 1'b1);
            check("R7 stop below threshold 8", stop_go, 1'b0);
            check("R6 echo mirrors one", echo, 1'b1);
        end
        frame(1'b1, 1'b1);
        check("R3 go at 8 ones prio0", stop_go, 1'b1);
    endtask

    task automatic t_zero_clear;
        do_reset(1'b0, 3'b011);
        for (int i = 0; i < 5; i++) frame(1'b1, 1'b1);
        frame(1'b0, 1'b1);
        check("R6 echo mirrors zero", echo, 1'b0);
        for (int i = 0; i < 7; i++) frame(1'b1, 1'b1);
        check("R2 zero cleared run", stop_go, 1'b0);
        frame(1'b1, 1'b1);
        check("R2 8 ones after zero", stop_go, 1'b1);
        frame(1'b0, 1'b1);
        check("R2 zero drops go", stop_go, 1'b0);
    endtask

    task automatic t_prio10;
        do_reset(1'b1, 3'b011);
        for (int i = 0; i < 9; i++) frame(1'b1, 1'b1);
        check("R3 stop at 9 ones prio1", stop_go, 1'b0);
        frame(1'b1, 1'b1);
        check("R3 go at 10 ones prio1", stop_go, 1'b1);
    endtask

    task automatic t_saturate;
        do_reset(1'b0, 3'b011);
        for (int i = 0; i < 12; i++) frame(1'b1, 1'b1);
        @(negedge clk);
        prio_sel = 1'b1;
        @(negedge clk);
        check("R2 count saturated at 10", stop_go, 1'b1);
    endtask

    task automatic t_grant;
        do_reset(1'b0, 3'b011);
        for (int i = 0; i < 8; i++) frame(1'b1, 1'b1);
        frame(1'b1, 1'b0);
        check("R4 grant gives go", stop_go, 1'b1);
        check("R5 echo inverted one", echo, 1'b0);
        frame(1'b0, 1'b0);
        check("R5 echo inverted zero", echo, 1'b1);
        check("R4 grant held over zero", stop_go, 1'b1);
        frame(1'b1, 1'b0);
        check("R5 echo inverted again", echo, 1'b0);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            d_bit = i[0]; req_n = ~i[0];
        end
        @(negedge clk);
        check("R9 go stable between strobes", stop_go, 1'b1);
        check("R9 echo stable between strobes", echo, 1'b0);
        frame(1'b1, 1'b1);
        check("R8 release gives stop", stop_go, 1'b0);
        check("R8 echo mirrors after release", echo, 1'b1);
        for (int i = 0; i < 7; i++) frame(1'b1, 1'b1);
        check("R8 count restarted (7 ones)", stop_go, 1'b0);
        frame(1'b1, 1'b1);
        check("R8 go after fresh 8 ones", stop_go, 1'b1);
    endtask

    task automatic t_immediate;
        do_reset(1'b0, 3'b011);
        for (int i = 0; i < 7; i++) begin
            frame(1'b1, 1'b0);
            check("R4 no grant before threshold", stop_go, 1'b0);
            check("R6 echo mirrors while waiting", echo, 1'b1);
        end
        frame(1'b1, 1'b0);
        check("R4 grant on threshold slot", stop_go, 1'b1);
        check("R5 echo inverted on grant slot", echo, 1'b0);
    endtask

    task automatic t_mode_off;
        do_reset(1'b0, 3'b000);
        for (int i = 0; i < 12; i++) frame(1'b1, 1'b0);
        check("R1 no go in mode 000", stop_go, 1'b0);
        check("R1 echo mirrors in mode 000", echo, 1'b1);
        frame(1'b0, 1'b0);
        check("R1 echo mirrors zero in mode 000", echo, 1'b0);
        do_reset(1'b0, 3'b111);
        for (int i = 0; i < 12; i++) frame(1'b1, 1'b0);
        check("R1 no go in mode 111", stop_go, 1'b0);
        check("R1 echo mirrors in mode 111", echo, 1'b1);
    endtask

    task automatic t_mode_drop;
        do_reset(1'b0, 3'b011);
        for (int i = 0; i < 8; i++) frame(1'b1, 1'b0);
        check("R4 grant before mode drop", stop_go, 1'b1);
        @(negedge clk);
        mode_cfg = 3'b001;
        @(negedge clk);
        check("R1 mode drop releases grant", stop_go, 1'b0);
        frame(1'b1, 1'b0);
        check("R1 echo mirrors after mode drop", echo, 1'b1);
    endtask

    initial begin
        rst = 1'b1; frame_stb = 1'b0; d_bit = 1'b1; req_n = 1'b1;
        prio_sel = 1'b0; mode_cfg = 3'b011;
        t_reset;
        t_count8;
        t_zero_clear;
        t_prio10;
        t_saturate;
        t_grant;
        t_immediate;
        t_mode_off;
        t_mode_drop;
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", checks, fails);
            $finish;
        end
    end
endmodule